// File: doc/BRIEF.md
# Move-Class Instruction Decoder

This combinational decoder handles the data-transfer group of a RISC instruction set that mixes 16-bit base instructions with 32-bit extended forms. The first halfword arrives on `ins_first` and the following halfword on `ins_second`. The outputs describe the operation:

- an operation mode code;
- destination, source and address-update register indices;
- the access size and whether a load is sign-extended;
- a ready-made 32-bit immediate or displacement;
- the instruction length in bytes;
- write and access enables.

An execute stage or a register/memory sequencer uses these outputs. Nothing here touches the register file or memory.

Immediates are built in four ways:
- an 8-bit value, sign-extended;
- a 20-bit value made from four bits of the first halfword and all of the second, sign-extended from bit 19;
- the same 20-bit value shifted left by eight bits;
- a 12-bit displacement, scaled by the access size for word loads.

Post-increment loads skip the address update when the address register is also the destination. An encoding outside the supported set raises `illegal` and keeps every enable low.

Top module: `xfer_decode`

## Requirements
- R1: `0110 nnnn mmmm 0011` gives mode 1 (register move). `rd_idx`=n, `rs_idx`=m, size 2, `reg_we`=1, length 2, and no memory access.
- R2: `0110 n m 00ss`, with ss of 0, 1 or 2, gives mode 3 (indirect load). Size codes are 0=byte, 1=word, 2=long. `rd_idx`=n and `rs_idx`=m. `sign_ext` is 1 for byte and word and 0 for long. `reg_we` and `mem_rd` are 1.
- R3: `0010 n m 00ss` gives mode 4 (indirect store). `0010 n m 01ss` gives mode 5 (pre-decrement store), which also sets `base_we`=1 with `base_idx`=n. Both set `mem_wr`=1, `rd_idx`=n (address) and `rs_idx`=m (data).
- R4: `0110 n m 01ss` gives mode 6 (post-increment load) with `base_idx`=m. `base_we` is 1 only when m differs from n.
- R5: `1110 n iiiiiiii` gives mode 2 (immediate load). `imm_val` is the 8-bit field sign-extended, `rd_idx`=n and `reg_we`=1.
- R6: a first halfword `0000 n hhhh 0000` gives mode 2 with length 4. `imm_val` is the 20-bit value {hhhh, `ins_second`} sign-extended from bit 19, and `rd_idx`=n.
- R7: a first halfword `0000 n hhhh 0001` gives mode 2 with length 4. `imm_val` is the R6 value shifted left by 8.
- R8: a first halfword `0011 n m 0001` gives mode 9 (displacement load, length 4) when the top nibble of `ins_second` is one of the following. In each case `rd_idx`=n and `rs_idx`=m.
  - 0100: signed byte, `imm_val`=disp12.
  - 1000: unsigned byte (`sign_ext`=0), `imm_val`=disp12.
  - 0101: signed word, `imm_val`=disp12*2.
- R9: `0100 m 11ss 1011` gives mode 7 (pre-decrement load into register 0). `rd_idx`=0, `rs_idx`=`base_idx`=m, and `reg_we`, `mem_rd` and `base_we` are all 1.
- R10: `0100 n 10ss 1011` gives mode 8 (post-increment store of register 0). `rd_idx`=`base_idx`=n, `rs_idx`=0, and `mem_wr` and `base_we` are 1.
- R11: any other encoding, including ss=3 and unknown nibbles, gives mode 0 with `illegal`=1. It also forces all enables and indices to 0, `imm_val`=0 and length 2.
- R12: 16-bit forms ignore `ins_second` completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ins_first | input | 16 | First instruction halfword |
| ins_second | input | 16 | Second halfword, used only by 32-bit forms |
| op_mode | output | 4 | Operation mode code |
| rd_idx | output | 4 | Destination (or store address) register |
| rs_idx | output | 4 | Source (or load address) register |
| base_idx | output | 4 | Register whose address is updated |
| acc_size | output | 2 | 0 byte, 1 word, 2 long |
| sign_ext | output | 1 | Loaded data is sign-extended |
| imm_val | output | 32 | Formed immediate or scaled displacement |
| ins_len | output | 3 | Instruction length in bytes (2 or 4) |
| reg_we | output | 1 | Destination register write |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| base_we | output | 1 | Address register update |
| illegal | output | 1 | No supported pattern matched |

## Verification
The decoder holds no state, so a wrong selection shows at the ports in the same evaluation as the input word. The possible errors are a misrouted nibble, a bad extension bit or a stray enable. Because the outputs settle combinationally, every check applies a word and samples one time step later. The aliasing rule for post-increment loads is probed with equal and unequal register fields. The 32-bit forms are also probed with negative and positive upper bits so that errors in the extension and the shift show up as distinct values.

// File: rtl/xfer_decode.sv
module xfer_decode (
  input  logic [15:0] ins_first,
  input  logic [15:0] ins_second,
  output logic [3:0]  op_mode,
  output logic [3:0]  rd_idx,
  output logic [3:0]  rs_idx,
  output logic [3:0]  base_idx,
  output logic [1:0]  acc_size,
  output logic        sign_ext,
  output logic [31:0] imm_val,
  output logic [2:0]  ins_len,
  output logic        reg_we,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        base_we,
  output logic        illegal
);
  localparam logic [3:0] M_NONE = 4'd0, M_MOVE = 4'd1, M_IMM = 4'd2, M_LDI = 4'd3,
                         M_STI = 4'd4, M_STDEC = 4'd5, M_LDINC = 4'd6, M_LDDEC0 = 4'd7,
                         M_STINC0 = 4'd8, M_LDDSP = 4'd9;
  localparam logic [1:0] SZ_LONG = 2'd2;

  logic [3:0]  top, fn, fm, low;
  logic [19:0] imm20;
  logic [31:0] imm20_x;

  assign top     = ins_first[15:12];
  assign fn      = ins_first[11:8];
  assign fm      = ins_first[7:4];
  assign low     = ins_first[3:0];
  assign imm20   = {ins_first[7:4], ins_second};
  assign imm20_x = {{12{imm20[19]}}, imm20};
  assign illegal = (op_mode == M_NONE);

  always_comb begin
    op_mode  = M_NONE;
    rd_idx   = '0;
    rs_idx   = '0;
    base_idx = '0;
    acc_size = '0;
    sign_ext = 1'b0;
    imm_val  = '0;
    ins_len  = 3'd2;
    reg_we   = 1'b0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    base_we  = 1'b0;
    unique case (top)
      4'b0110: begin
        if (low == 4'b0011) begin
          op_mode  = M_MOVE;
          rd_idx   = fn;
          rs_idx   = fm;
          acc_size = SZ_LONG;
          reg_we   = 1'b1;
        end else if (!low[3] && low[1:0] != 2'b11) begin
          op_mode  = low[2] ? M_LDINC : M_LDI;
          rd_idx   = fn;
          rs_idx   = fm;
          acc_size = low[1:0];
          sign_ext = (low[1:0] != SZ_LONG);
          reg_we   = 1'b1;
          mem_rd   = 1'b1;
          if (low[2]) begin
            base_idx = fm;
            base_we  = (fm != fn);
          end
        end
      end
      4'b0010: begin
        if (!low[3] && low[1:0] != 2'b11) begin
          op_mode  = low[2] ? M_STDEC : M_STI;
          rd_idx   = fn;
          rs_idx   = fm;
          acc_size = low[1:0];
          mem_wr   = 1'b1;
          if (low[2]) begin
            base_idx = fn;
            base_we  = 1'b1;
          end
        end
      end
      4'b1110: begin
        op_mode  = M_IMM;
        rd_idx   = fn;
        acc_size = SZ_LONG;
        imm_val  = {{24{ins_first[7]}}, ins_first[7:0]};
        reg_we   = 1'b1;
      end
      4'b0000: begin
        if (low[3:1] == 3'b000) begin
          op_mode  = M_IMM;
          rd_idx   = fn;
          acc_size = SZ_LONG;
          imm_val  = low[0] ? {imm20_x[23:0], 8'h00} : imm20_x;
          ins_len  = 3'd4;
          reg_we   = 1'b1;
        end
      end
      4'b0100: begin
        if (low == 4'b1011 && ins_first[7] && ins_first[5:4] != 2'b11) begin
          op_mode  = ins_first[6] ? M_LDDEC0 : M_STINC0;
          acc_size = ins_first[5:4];
          base_idx = fn;
          base_we  = 1'b1;
          if (ins_first[6]) begin
            rs_idx   = fn;
            sign_ext = (ins_first[5:4] != SZ_LONG);
            reg_we   = 1'b1;
            mem_rd   = 1'b1;
          end else begin
            rd_idx   = fn;
            mem_wr   = 1'b1;
          end
        end
      end
      4'b0011: begin
        if (low == 4'b0001 && (ins_second[15:12] == 4'b0100 ||
            ins_second[15:12] == 4'b1000 || ins_second[15:12] == 4'b0101)) begin
          op_mode  = M_LDDSP;
          rd_idx   = fn;
          rs_idx   = fm;
          ins_len  = 3'd4;
          reg_we   = 1'b1;
          mem_rd   = 1'b1;
          acc_size = {1'b0, ins_second[12]};
          sign_ext = !ins_second[15];
          imm_val  = ins_second[12] ? {19'd0, ins_second[11:0], 1'b0}
                                    : {20'd0, ins_second[11:0]};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_decode_chk.sv
module xfer_decode_chk (
  input logic [15:0] ins_first,
  input logic [3:0]  op_mode,
  input logic [3:0]  rd_idx,
  input logic [3:0]  rs_idx,
  input logic [1:0]  acc_size,
  input logic [2:0]  ins_len,
  input logic        reg_we,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        base_we,
  input logic        illegal
);
  always_comb begin
    p_illegal_quiet_r11: assert (!illegal || (!reg_we && !mem_rd && !mem_wr && !base_we && ins_len == 3'd2))
      else $error("illegal word left an enable active");
    p_rd_wr_excl_r3: assert (!(mem_rd && mem_wr))
      else $error("read and write both active");
    p_len_legal_r6: assert (ins_len == 3'd2 || ins_len == 3'd4)
      else $error("bad length");
    p_alias_noupd_r4: assert (!(op_mode == 4'd6 && rd_idx == rs_idx) || !base_we)
      else $error("aliased post-increment updates base");
    p_size_legal_r2: assert (acc_size != 2'd3)
      else $error("reserved size code");
    p_r0_dest_r9: assert (op_mode != 4'd7 || rd_idx == 4'd0)
      else $error("pre-decrement load not into register 0");
  end
endmodule

bind xfer_decode xfer_decode_chk u_chk (
  .ins_first(ins_first), .op_mode(op_mode), .rd_idx(rd_idx), .rs_idx(rs_idx),
  .acc_size(acc_size), .ins_len(ins_len), .reg_we(reg_we), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .base_we(base_we), .illegal(illegal)
);

// File: tb/xfer_decode_test.sv
module xfer_decode_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] ins_first = '0, ins_second = '0;
  logic [3:0]  op_mode, rd_idx, rs_idx, base_idx;
  logic [1:0]  acc_size;
  logic        sign_ext, reg_we, mem_rd, mem_wr, base_we, illegal;
  logic [31:0] imm_val;
  logic [2:0]  ins_len;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_decode uut (
    .ins_first(ins_first), .ins_second(ins_second), .op_mode(op_mode), .rd_idx(rd_idx),
    .rs_idx(rs_idx), .base_idx(base_idx), .acc_size(acc_size), .sign_ext(sign_ext),
    .imm_val(imm_val), .ins_len(ins_len), .reg_we(reg_we), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .base_we(base_we), .illegal(illegal)
  );

  task automatic cmp(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    ins_first  = a;
    ins_second = b;
    #1;
  endtask

  // mode rd rs base size sx imm len {reg_we,mem_rd,mem_wr,base_we,illegal}
  task automatic expect_all(string tag, logic [3:0] m, logic [3:0] d, logic [3:0] s,
                            logic [3:0] bi, logic [1:0] sz, logic sx, logic [31:0] im,
                            logic [2:0] ln, logic [4:0] en);
    cmp(tag, "mode", op_mode, m);
    cmp(tag, "rd", rd_idx, d);
    cmp(tag, "rs", rs_idx, s);
    cmp(tag, "base", base_idx, bi);
    cmp(tag, "size", acc_size, sz);
    cmp(tag, "sext", sign_ext, sx);
    cmp(tag, "imm", imm_val, im);
    cmp(tag, "len", ins_len, ln);
    cmp(tag, "enables", {reg_we, mem_rd, mem_wr, base_we, illegal}, en);
  endtask

  task automatic t_zero_word;
    apply(16'h0000, 16'h0000);
    expect_all("R6 zero word", 2, 0, 0, 0, 2, 0, 32'h0, 4, 5'b10000);
  endtask

  task automatic t_move_r1;
    apply(16'h6A53, 16'h0000);
    expect_all("R1", 1, 4'hA, 5, 0, 2, 0, 0, 2, 5'b10000);
  endtask

  task automatic t_load_r2;
    apply(16'h6340, 16'h0);
    expect_all("R2 byte", 3, 3, 4, 0, 0, 1, 0, 2, 5'b11000);
    apply(16'h6341, 16'h0);
    expect_all("R2 word", 3, 3, 4, 0, 1, 1, 0, 2, 5'b11000);
    apply(16'h6342, 16'h0);
    expect_all("R2 long", 3, 3, 4, 0, 2, 0, 0, 2, 5'b11000);
  endtask

  task automatic t_store_r3;
    apply(16'h2A70, 16'h0);
    expect_all("R3 store", 4, 4'hA, 7, 0, 0, 0, 0, 2, 5'b00100);
    apply(16'h2A76, 16'h0);
    expect_all("R3 predec", 5, 4'hA, 7, 4'hA, 2, 0, 0, 2, 5'b00110);
  endtask

  task automatic t_postinc_r4;
    apply(16'h6356, 16'h0);
    expect_all("R4 distinct", 6, 3, 5, 5, 2, 0, 0, 2, 5'b11010);
    apply(16'h6336, 16'h0);
    expect_all("R4 alias", 6, 3, 3, 3, 2, 0, 0, 2, 5'b11000);
    apply(16'h6354, 16'h0);
    expect_all("R4 byte", 6, 3, 5, 5, 0, 1, 0, 2, 5'b11010);
  endtask

  task automatic t_imm8_r5;
    apply(16'hE480, 16'h0);
    expect_all("R5 neg", 2, 4, 0, 0, 2, 0, 32'hFFFFFF80, 2, 5'b10000);
    apply(16'hE47F, 16'h0);
    expect_all("R5 pos", 2, 4, 0, 0, 2, 0, 32'h0000007F, 2, 5'b10000);
  endtask

  task automatic t_imm20_r6;
    apply(16'h0280, 16'h1234);
    expect_all("R6 neg", 2, 2, 0, 0, 2, 0, 32'hFFF81234, 4, 5'b10000);
    apply(16'h0370, 16'hABCD);
    expect_all("R6 pos", 2, 3, 0, 0, 2, 0, 32'h0007ABCD, 4, 5'b10000);
  endtask

  task automatic t_imm20s_r7;
    apply(16'h0281, 16'h1234);
    expect_all("R7 neg", 2, 2, 0, 0, 2, 0, 32'hF8123400, 4, 5'b10000);
    apply(16'h0171, 16'hFFFF);
    expect_all("R7 pos", 2, 1, 0, 0, 2, 0, 32'h07FFFF00, 4, 5'b10000);
  endtask

  task automatic t_disp_r8;
    apply(16'h3561, 16'h4FFF);
    expect_all("R8 sbyte", 9, 5, 6, 0, 0, 1, 32'h00000FFF, 4, 5'b11000);
    apply(16'h3561, 16'h8ABC);
    expect_all("R8 ubyte", 9, 5, 6, 0, 0, 0, 32'h00000ABC, 4, 5'b11000);
    apply(16'h3561, 16'h5800);
    expect_all("R8 word", 9, 5, 6, 0, 1, 1, 32'h00001000, 4, 5'b11000);
    apply(16'h3561, 16'h2000);
    expect_all("R8 bad sub R11", 0, 0, 0, 0, 0, 0, 0, 2, 5'b00001);
  endtask

  task automatic t_r0_r9_r10;
    apply(16'h49CB, 16'h0);
    expect_all("R9 byte", 7, 0, 9, 9, 0, 1, 0, 2, 5'b11010);
    apply(16'h49EB, 16'h0);
    expect_all("R9 long", 7, 0, 9, 9, 2, 0, 0, 2, 5'b11010);
    apply(16'h4C9B, 16'h0);
    expect_all("R10 word", 8, 4'hC, 0, 4'hC, 1, 0, 0, 2, 5'b00110);
  endtask

  task automatic t_illegal_r11;
    apply(16'h6A57, 16'h0);
    expect_all("R11 6xx7", 0, 0, 0, 0, 0, 0, 0, 2, 5'b00001);
    apply(16'h2A53, 16'h0);
    expect_all("R11 2xx3", 0, 0, 0, 0, 0, 0, 0, 2, 5'b00001);
    apply(16'h0282, 16'h1234);
    expect_all("R11 0xx2", 0, 0, 0, 0, 0, 0, 0, 2, 5'b00001);
    apply(16'h4CBB, 16'h0);
    expect_all("R11 size3", 0, 0, 0, 0, 0, 0, 0, 2, 5'b00001);
    apply(16'hFFFF, 16'hFFFF);
    expect_all("R11 FFFF", 0, 0, 0, 0, 0, 0, 0, 2, 5'b00001);
  endtask

  task automatic t_second_ignored_r12;
    apply(16'h6A53, 16'hFFFF);
    expect_all("R12 move", 1, 4'hA, 5, 0, 2, 0, 0, 2, 5'b10000);
    apply(16'hE480, 16'h7F7F);
    expect_all("R12 imm8", 2, 4, 0, 0, 2, 0, 32'hFFFFFF80, 2, 5'b10000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_zero_word();
    t_move_r1();
    t_load_r2();
    t_store_r3();
    t_postinc_r4();
    t_imm8_r5();
    t_imm20_r6();
    t_imm20s_r7();
    t_disp_r8();
    t_r0_r9_r10();
    t_illegal_r11();
    t_second_ignored_r12();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule